// File: doc/BRIEF.md
# Critical Error Debug Entry Controller

This block settles what a hart does once it has fallen into an unrecoverable critical-error condition. A single writable enable bit in the debug control/status register picks the outcome. With the bit clear, the hart signals the platform through a registered critical-error output. With the bit set, the hart is taken into Debug Mode instead, and the debug cause fields record that a critical error was the reason.

The block also ranks debug-entry requests. Other sources present a valid bit together with a cause and an extended cause. A critical error with the enable set beats all of them. Among the other sources, the lowest index wins. The critical-error condition is sticky. A resume from Debug Mode therefore drops the hart straight back into that condition. With the enable still set, debug entry then repeats after a single cycle outside Debug Mode.

Top module: `crit_dbg_entry`

## Requirements
- R1: The enable bit is stored at bit 19 of the register. It reads back from `csr_rdata_o[19]` in the cycle after a write with `csr_we_i` high, and it is 0 after reset.
- R2: Every bit of `csr_rdata_o` other than bit 19 reads as 0, including bits 23:20 and bit 18. Write data on those bits is discarded.
- R3: A one-cycle `crit_err_i` pulse makes the critical-error condition sticky, and only reset clears it. It persists across debug entries and resumes.
- R4: With the enable clear, `crit_err_o` is high in the cycle after the edge that samples `crit_err_i`. It stays high while the condition holds and the hart is outside Debug Mode. Debug Mode is not entered because of it, and `crit_err_o` is never high together with `debug_mode_o`.
- R5: With the enable set, the condition raises `debug_mode_o` in the cycle after the sampling edge, and `crit_err_o` stays low.
- R6: A critical-error entry sets `cause_o` to 7 and `extcause_o` to 0.
- R7: When a critical-error entry and other requests arrive in the same cycle, the critical-error cause wins.
- R8: `dbg_entry_o` is high for exactly one cycle, the first cycle of `debug_mode_o`. The cause fields change in that same cycle.
- R9: `resume_i` in Debug Mode clears `debug_mode_o` at the next edge. If the condition holds and the enable is set, Debug Mode is re-entered one cycle later.
- R10: A write to the enable during Debug Mode does not change `debug_mode_o` or `crit_err_o` before the resume. If the enable was cleared, `crit_err_o` rises together with the fall of `debug_mode_o`.
- R11: Without a critical-error entry, the valid request with the lowest index enters Debug Mode. Its `req_cause_i[3i+2:3i]` and `req_ext_i[EXT_W*i+EXT_W-1:EXT_W*i]` become `cause_o` and `extcause_o`.
- R12: While in Debug Mode, requests and critical-error pulses leave `cause_o` and `extcause_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crit_err_i | input | 1 | Critical-error event |
| req_valid_i | input | NUM_REQ | Other debug-entry requests, index 0 highest |
| req_cause_i | input | 3*NUM_REQ | Cause for each request |
| req_ext_i | input | EXT_W*NUM_REQ | Extended cause for each request |
| resume_i | input | 1 | Resume request from Debug Mode |
| csr_we_i | input | 1 | Register write strobe |
| csr_wdata_i | input | XLEN | Register write data |
| csr_rdata_o | output | XLEN | Register read data |
| debug_mode_o | output | 1 | Hart is in Debug Mode |
| dbg_entry_o | output | 1 | One-cycle debug-entry pulse |
| cause_o | output | 3 | Latched debug cause |
| extcause_o | output | EXT_W | Latched extended cause |
| crit_err_o | output | 1 | Critical-error signal to the platform |

## Verification
A lost or falsely set sticky condition shows within one cycle of the next resume. In that case the one-cycle re-entry either fails to happen or appears without cause, or `crit_err_o` disagrees with the model. A wrong enable state shows at the next sampling edge, both on `csr_rdata_o` and in the choice between `crit_err_o` and `debug_mode_o`. Priority or latching errors surface as a wrong `cause_o`/`extcause_o` in the first cycle of Debug Mode. The bench compares every output against a behavioural model on every clock, so each of these faults is caught in the cycle it first appears.

// File: rtl/crit_dbg_entry.sv
module crit_dbg_entry #(
  parameter int NUM_REQ = 4,
  parameter int EXT_W   = 4,
  parameter int XLEN    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     crit_err_i,
  input  logic [NUM_REQ-1:0]       req_valid_i,
  input  logic [3*NUM_REQ-1:0]     req_cause_i,
  input  logic [EXT_W*NUM_REQ-1:0] req_ext_i,
  input  logic                     resume_i,
  input  logic                     csr_we_i,
  input  logic [XLEN-1:0]          csr_wdata_i,
  output logic [XLEN-1:0]          csr_rdata_o,
  output logic                     debug_mode_o,
  output logic                     dbg_entry_o,
  output logic [2:0]               cause_o,
  output logic [EXT_W-1:0]         extcause_o,
  output logic                     crit_err_o
);
  localparam int              EN_BIT     = 19;
  localparam logic [XLEN-1:0] EN_MASK    = XLEN'(1) << EN_BIT;
  localparam logic [2:0]      CRIT_CAUSE = 3'd7;

  logic en_q, crit_q, dbg_q, entry_q, cout_q;
  logic [2:0] cause_q;
  logic [EXT_W-1:0] ext_q;

  logic en_d, crit_d, crit_win, enter, dbg_d;
  logic req_any;
  logic [2:0] req_cause;
  logic [EXT_W-1:0] req_ext;

  always_comb begin
    req_any   = 1'b0;
    req_cause = '0;
    req_ext   = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (req_valid_i[i]) begin
        req_any   = 1'b1;
        req_cause = req_cause_i[3*i +: 3];
        req_ext   = req_ext_i[EXT_W*i +: EXT_W];
      end
    end
  end

  assign en_d     = csr_we_i ? |(csr_wdata_i & EN_MASK) : en_q;
  assign crit_d   = crit_q | crit_err_i;
  assign crit_win = crit_d & en_q;
  assign enter    = ~dbg_q & (crit_win | req_any);
  assign dbg_d    = enter | (dbg_q & ~resume_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      crit_q  <= 1'b0;
      dbg_q   <= 1'b0;
      entry_q <= 1'b0;
      cout_q  <= 1'b0;
      cause_q <= '0;
      ext_q   <= '0;
    end else begin
      en_q    <= en_d;
      crit_q  <= crit_d;
      dbg_q   <= dbg_d;
      entry_q <= enter;
      cout_q  <= crit_d & ~dbg_d & ~en_d;
      if (enter) begin
        cause_q <= crit_win ? CRIT_CAUSE : req_cause;
        ext_q   <= crit_win ? '0 : req_ext;
      end
    end
  end

  assign csr_rdata_o  = en_q ? EN_MASK : '0;
  assign debug_mode_o = dbg_q;
  assign dbg_entry_o  = entry_q;
  assign cause_o      = cause_q;
  assign extcause_o   = ext_q;
  assign crit_err_o   = cout_q;

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    crit_q |=> crit_q);

  assert_out_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    crit_err_o |-> !debug_mode_o);

  assert_crit_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(debug_mode_o) && $past(crit_d && en_q)) |-> (cause_o == CRIT_CAUSE && extcause_o == '0));

  assert_entry_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_entry_o |-> (debug_mode_o && !$past(debug_mode_o)));

  assert_reenter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(debug_mode_o) && crit_q && en_q) |=> debug_mode_o);

  assert_cause_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (debug_mode_o && $past(debug_mode_o)) |-> ($stable(cause_o) && $stable(extcause_o)));
endmodule

// File: tb/crit_dbg_entry_tb.sv
`timescale 1ns/100ps
module crit_dbg_entry_tb;
  localparam int NR = 4;
  localparam int EW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic crit_err = 1'b0;
  logic [NR-1:0] rv = '0;
  logic [3*NR-1:0] rc = '0;
  logic [EW*NR-1:0] re = '0;
  logic resume = 1'b0;
  logic we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic dbg, pulse, cout;
  logic [2:0] cause;
  logic [EW-1:0] ext;

  always #2.5 clk = ~clk;

  crit_dbg_entry #(.NUM_REQ(NR), .EXT_W(EW), .XLEN(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .crit_err_i(crit_err), .req_valid_i(rv),
    .req_cause_i(rc), .req_ext_i(re), .resume_i(resume), .csr_we_i(we),
    .csr_wdata_i(wd), .csr_rdata_o(rdata), .debug_mode_o(dbg),
    .dbg_entry_o(pulse), .cause_o(cause), .extcause_o(ext), .crit_err_o(cout));

  int checks = 0;
  int errors = 0;
  string ph = "reset";

  bit m_en, m_crit, m_dbg, m_pulse, m_cout;
  int m_cause, m_ext;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, ph, act, exp);
    end
  endtask

  task automatic model();
    bit en_n, crit_n, ent;
    if (!rst_n) begin
      m_en = 0; m_crit = 0; m_dbg = 0; m_pulse = 0; m_cout = 0; m_cause = 0; m_ext = 0;
      return;
    end
    en_n   = we ? wd[19] : m_en;
    crit_n = m_crit || crit_err;
    ent    = 0;
    if (!m_dbg) begin
      if (crit_n && m_en) begin
        ent = 1; m_cause = 7; m_ext = 0;
      end else begin
        for (int i = 0; i < NR; i++) begin
          if (rv[i] && !ent) begin
            ent = 1; m_cause = rc[3*i +: 3]; m_ext = re[EW*i +: EW];
          end
        end
      end
      m_dbg = ent;
    end else if (resume) begin
      m_dbg = 0;
    end
    m_pulse = ent;
    m_en    = en_n;
    m_crit  = crit_n;
    m_cout  = crit_n && !m_dbg && !en_n;
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    chk("R1/R2 rdata", rdata, m_en ? 32'h0008_0000 : 0);
    chk("R4/R10 crit_err_o", cout, m_cout);
    chk("R5/R9 debug_mode_o", dbg, m_dbg);
    chk("R8 dbg_entry_o", pulse, m_pulse);
    chk("R6/R11 cause_o", cause, m_cause);
    chk("R6/R11 extcause_o", ext, m_ext);
  endtask

  task automatic idle(); crit_err = 0; rv = '0; resume = 0; we = 0; endtask
  task automatic setreq(int i, int c, int e);
    rv[i] = 1; rc[3*i +: 3] = 3'(c); re[EW*i +: EW] = EW'(e);
  endtask
  task automatic wr(logic [31:0] v); we = 1; wd = v; step(); we = 0; endtask
  task automatic run(int n); for (int k = 0; k < n; k++) step(); endtask
  task automatic do_reset(); rst_n = 0; idle(); run(2); rst_n = 1; step(); endtask

  initial begin
    fork
      begin
        ph = "reset R1";
        run(2); rst_n = 1; step();
        chk("R1 reset enable", rdata[19], 0);
        chk("R4 reset crit_err_o", cout, 0);

        ph = "R2 reserved bits";
        wr(32'hFFF7_FFFF);
        chk("R2 reserved read zero", rdata, 0);
        ph = "R1 enable write";
        wr(32'h00FC_0000);
        chk("R1 enable set", rdata, 32'h0008_0000);
        wr(32'h0);

        ph = "R11 request priority";
        setreq(2, 3, 5); setreq(1, 2, 9); step(); idle();
        chk("R11 lowest index wins cause", cause, 2);
        chk("R11 lowest index wins ext", ext, 9);
        run(2);
        resume = 1; step(); resume = 0; run(2);
        setreq(3, 4, 1); step(); idle(); run(1);
        resume = 1; step(); resume = 0; run(1);

        ph = "R4 crit with enable clear";
        crit_err = 1; step(); crit_err = 0;
        chk("R4 crit_err_o after event", cout, 1);
        chk("R4 no debug entry", dbg, 0);
        run(4);
        ph = "R3 sticky through request entry";
        setreq(0, 1, 3); step(); idle();
        chk("R4 exclusive with debug", cout, 0);
        run(2); resume = 1; step(); resume = 0;
        chk("R3 condition kept after resume", cout, 1);
        run(3);

        ph = "R5 enable set while in condition";
        wr(32'h0008_0000);
        chk("R5 crit_err_o drops", cout, 0);
        step();
        chk("R5 debug entered", dbg, 1);
        chk("R6 cause 7", cause, 7);
        run(2);

        ph = "R7 R9 reentry";
        do_reset();
        wr(32'h0008_0000);
        crit_err = 1; setreq(0, 4, 6); setreq(2, 1, 2); step(); idle();
        chk("R7 crit beats requests", cause, 7);
        chk("R6 extcause 0", ext, 0);
        chk("R8 pulse on entry", pulse, 1);
        step();
        chk("R8 pulse one cycle", pulse, 0);
        ph = "R12 ignored in debug";
        setreq(0, 2, 15); crit_err = 1; run(3); idle();
        chk("R12 cause held", cause, 7);
        chk("R12 ext held", ext, 0);
        ph = "R9 resume";
        resume = 1; step(); resume = 0;
        chk("R9 left debug", dbg, 0);
        chk("R9 no crit_err_o", cout, 0);
        step();
        chk("R9 reentered", dbg, 1);
        chk("R9 reentry pulse", pulse, 1);
        run(2);

        ph = "R10 enable cleared in debug";
        wr(32'h0);
        chk("R10 still in debug", dbg, 1);
        chk("R10 no crit_err_o yet", cout, 0);
        run(3);
        resume = 1; step(); resume = 0;
        chk("R10 crit_err_o after resume", cout, 1);
        chk("R10 debug left", dbg, 0);
        run(3);
        chk("R3 stays out of debug", dbg, 0);

        ph = "R3 reset clears";
        do_reset();
        chk("R3 cleared by reset", cout, 0);
        wr(32'h0008_0000); run(2);
        chk("R3 no entry after reset", dbg, 0);
        run(2);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule